// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and raises `intr` to the processor. A single-cycle `inta` pulse acknowledges the interrupt. The block then moves the winning level from its request register into its in-service register and returns an 8-bit vector. The upper five bits of that vector are programmed and the lower three bits hold the level. Software reaches the block through two addresses. Address 0 is the command port and address 1 is the data port. A fixed sequence of setup words programs the vector base, the cascade layout and the end-of-interrupt mode.

Two instances can be tiled into sixteen lines. The slave's `intr` feeds one master input, and the master's cascade select outputs feed the slave's cascade inputs. When the master acknowledges a level that has a slave behind it, the master drives the level number on the cascade outputs and stays silent, and the matching slave supplies the vector. Software ends a cascaded interrupt with a specific EOI to the slave first and then a specific EOI for the cascade level to the master.

The setup sequencer is a four-state machine:
- `ST_READY` is the operating state, in which data writes load the mask.
- `ST_WORD2` expects the vector-base word.
- `ST_WORD3` expects the cascade word.
- `ST_WORD4` expects the mode word.

Its transitions:
- Any state goes to `ST_WORD2` on an init command.
- `ST_WORD2` goes to `ST_WORD3` on a data write.
- `ST_WORD3` goes to `ST_WORD4` on a data write.
- `ST_WORD4` goes to `ST_READY` on a data write.
- Every state holds otherwise.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the request and in-service registers are 0, `intr` is 0 and command-port reads return the request register.
- R2: A command-port write with bit 4 set (0x11) clears the request and in-service registers and selects request-register reads. The next three data-port writes are taken as the base word, the cascade word and the mode word, and later data writes load the mask. The mask itself is left unchanged by the sequence.
- R3: A vector is `{base word[7:3], level}` and is presented with `vec_valid` high for exactly one cycle, the cycle after the clock edge that samples `inta`.
- R4: Outside setup, a data-port write loads the mask and a data-port read returns it. A mask bit of 1 keeps that line's latched request from raising `intr` or being acknowledged.
- R5: A command write of 0x0A selects request-register reads on the command port and 0x0B selects in-service reads. The selection holds until it is changed.
- R6: A rising input edge sets the line's request bit. The bit clears when the line goes low before acknowledge.
- R7: Priority is fixed with input 0 highest. `intr` is high only when an unmasked request outranks every level in service.
- R8: In normal EOI mode an acknowledge clears the winner's request bit and sets its in-service bit.
- R9: A command write of 0x60 plus n (n from 0 to 7) clears only in-service bit n.
- R10: When mode word bit 1 is set (auto-EOI), an acknowledge sets no in-service bit.
- R11: An acknowledge with no eligible request returns the level-7 vector and leaves the in-service register unchanged, whether or not level 7 is masked.
- R12: In master mode the cascade word is a bitmask of the inputs that have slaves. Acknowledging such an input drives `cas_out` to the level with `cas_out_vld` high during `inta`, sets the in-service bit and gives no master vector.
- R13: In slave mode, cascade word bits [2:0] are the slave's identity. The slave answers `inta` only while `cas_in_vld` is high and `cas_in` equals that identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 selects slave behaviour |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 is the command port, 1 is the data port |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| irq_in | input | 8 | Interrupt request lines |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Single-cycle acknowledge |
| cas_in | input | 3 | Cascade select from the master (slave mode) |
| cas_in_vld | input | 1 | Cascade select valid (slave mode) |
| cas_out | output | 3 | Cascade select to slaves (master mode) |
| cas_out_vld | output | 1 | Cascade select valid |
| vec_out | output | 8 | Interrupt vector |
| vec_valid | output | 1 | Vector strobe |

## Verification
Register writes take effect at the clock edge that samples them, and a read is correct from the next half cycle. A rising request edge shows on `intr` and in the request register right after the edge that samples it. The vector strobe follows one edge after `inta`, while the cascade select is combinational within the `inta` cycle and is sampled before that edge. The bench drives inputs just after falling edges, updates its behavioural model at rising edges and compares `intr`, the vector and the read port at every falling edge. Directed checks cover the slave and the cascade select at the same points in the cycle.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    typedef enum logic [1:0] {
        ST_READY,
        ST_WORD2,
        ST_WORD3,
        ST_WORD4
    } cfg_state_e;

    localparam logic [2:0] OP_EOI_SPEC = 3'b011;
    localparam logic [1:0] OP_RD_SEL   = 2'b01;
endpackage

// File: rtl/pic8_regif.sv
module pic8_regif
    import pic8_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_IN   = 8,
    localparam int LVL_W = $clog2(N_IN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [DATA_W-LVL_W-1:0] base_hi,
    output logic [N_IN-1:0]         cas_cfg,
    output logic                    aeoi,
    output logic [N_IN-1:0]         imr,
    output logic                    rd_isr,
    output logic                    init_start,
    output logic                    eoi_vld,
    output logic [LVL_W-1:0]        eoi_lvl
);
    cfg_state_e state, state_nx;
    logic cmd_wr, dat_wr, sel_wr;

    assign cmd_wr     = wr_en && !addr;
    assign dat_wr     = wr_en && addr;
    assign init_start = cmd_wr && wr_data[4];
    assign eoi_vld    = cmd_wr && !wr_data[4] && (wr_data[7:5] == OP_EOI_SPEC);
    assign eoi_lvl    = wr_data[LVL_W-1:0];
    assign sel_wr     = cmd_wr && (wr_data[4:3] == OP_RD_SEL) && wr_data[1];

    always_comb begin
        state_nx = state;
        if (init_start) begin
            state_nx = ST_WORD2;
        end else begin
            unique case (state)
                ST_READY: state_nx = ST_READY;
                ST_WORD2: if (dat_wr) state_nx = ST_WORD3;
                ST_WORD3: if (dat_wr) state_nx = ST_WORD4;
                ST_WORD4: if (dat_wr) state_nx = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            cas_cfg <= '0;
            aeoi    <= 1'b0;
            imr     <= '1;
            rd_isr  <= 1'b0;
        end else begin
            if (init_start)  rd_isr <= 1'b0;
            else if (sel_wr) rd_isr <= wr_data[0];
            if (dat_wr && !init_start) begin
                unique case (state)
                    ST_READY: imr     <= wr_data[N_IN-1:0];
                    ST_WORD2: base_hi <= wr_data[DATA_W-1:LVL_W];
                    ST_WORD3: cas_cfg <= wr_data[N_IN-1:0];
                    ST_WORD4: aeoi    <= wr_data[1];
                endcase
            end
        end
    end

    assert_init_enters_word2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> (state == ST_WORD2));
    assert_word4_returns_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WORD4 && dat_wr && !init_start) |=> (state == ST_READY));
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
    parameter int N_IN   = 8,
    localparam int LVL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  irr,
    input  logic [N_IN-1:0]  isr,
    input  logic [N_IN-1:0]  imr,
    output logic             req_any,
    output logic [LVL_W-1:0] req_lvl
);
    logic [N_IN-1:0] allow;
    logic [N_IN-1:0] elig;

    assign allow[0] = ~isr[0];
    for (genvar g = 1; g < N_IN; g++) begin : g_allow
        assign allow[g] = allow[g-1] & ~isr[g];
    end

    assign elig    = irr & ~imr & allow;
    assign req_any = |elig;

    always_comb begin
        req_lvl = '0;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (elig[i]) req_lvl = LVL_W'(i);
        end
    end
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl #(
    parameter int DATA_W = 8,
    parameter int N_IN   = 8,
    localparam int LVL_W = $clog2(N_IN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_IN-1:0]   irq_in,
    output logic              intr,
    input  logic              inta,
    input  logic [LVL_W-1:0]  cas_in,
    input  logic              cas_in_vld,
    output logic [LVL_W-1:0]  cas_out,
    output logic              cas_out_vld,
    output logic [DATA_W-1:0] vec_out,
    output logic              vec_valid
);
    logic [DATA_W-LVL_W-1:0] base_hi;
    logic [N_IN-1:0] cas_cfg, imr, irr, isr, irq_d, take_mask, eoi_mask;
    logic aeoi, rd_isr, init_start, eoi_vld, req_any, ack_me, casc_hit, ack_take;
    logic [LVL_W-1:0] eoi_lvl, req_lvl;

    pic8_regif #(.DATA_W(DATA_W), .N_IN(N_IN)) regif_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .base_hi(base_hi), .cas_cfg(cas_cfg), .aeoi(aeoi), .imr(imr),
        .rd_isr(rd_isr), .init_start(init_start), .eoi_vld(eoi_vld), .eoi_lvl(eoi_lvl)
    );

    pic8_prio #(.N_IN(N_IN)) prio_i (
        .irr(irr), .isr(isr), .imr(imr), .req_any(req_any), .req_lvl(req_lvl)
    );

    assign ack_me    = inta && (!slave_mode || (cas_in_vld && cas_in == cas_cfg[LVL_W-1:0]));
    assign casc_hit  = !slave_mode && req_any && cas_cfg[req_lvl];
    assign ack_take  = ack_me && req_any;
    assign take_mask = ack_take ? (N_IN'(1) << req_lvl) : '0;
    assign eoi_mask  = eoi_vld ? (N_IN'(1) << eoi_lvl) : '0;

    assign intr        = req_any;
    assign cas_out_vld = inta && casc_hit;
    assign cas_out     = (inta && casc_hit) ? req_lvl : '0;
    assign rd_data     = addr ? DATA_W'(imr) : DATA_W'(rd_isr ? isr : irr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr       <= '0;
            isr       <= '0;
            irq_d     <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            irq_d     <= irq_in;
            vec_valid <= ack_me && !casc_hit;
            if (ack_me && !casc_hit)
                vec_out <= {base_hi, (req_any ? req_lvl : {LVL_W{1'b1}})};
            if (init_start) begin
                irr <= '0;
                isr <= '0;
            end else begin
                irr <= ((irr | (irq_in & ~irq_d)) & irq_in) & ~take_mask;
                isr <= (isr & ~eoi_mask) | (aeoi ? '0 : take_mask);
            end
        end
    end

    assert_intr_needs_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
        intr |-> ((irr & ~imr) != '0));
    assert_vector_follows_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));
    assert_request_tracks_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irr & ~$past(irq_in)) == '0);
    assert_eoi_clears_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_vld && !ack_take) |=> (isr[$past(eoi_lvl)] == 1'b0));
    assert_auto_eoi_no_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_me && aeoi) |=> ((isr & ~$past(isr)) == '0));
    assert_spurious_no_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_me && !req_any) |=> ((isr & ~$past(isr)) == '0));
    assert_cascade_in_service_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_out_vld && !aeoi && !init_start) |=> isr[$past(cas_out)]);
    assert_slave_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !(cas_in_vld && cas_in == cas_cfg[LVL_W-1:0])) |=> !vec_valid);
endmodule

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       b_wr_m = 0, b_wr_s = 0, b_addr = 0, b_inta = 0;
    logic [7:0] b_data = 0, b_irq = 0, b_sirq = 0;
    logic [7:0] m_rd, s_rd, m_vec, s_vec, s_co_unused;
    logic       m_intr, s_intr, m_vv, s_vv, m_cov, s_cov_unused;
    logic [2:0] m_co, s_co;
    logic [7:0] m_irq_w;

    assign m_irq_w = {b_irq[7:3], s_intr, b_irq[1:0]};

    pic8_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .slave_mode(1'b0), .wr_en(b_wr_m), .addr(b_addr),
        .wr_data(b_data), .rd_data(m_rd), .irq_in(m_irq_w), .intr(m_intr), .inta(b_inta),
        .cas_in(3'd0), .cas_in_vld(1'b0), .cas_out(m_co), .cas_out_vld(m_cov),
        .vec_out(m_vec), .vec_valid(m_vv)
    );

    pic8_ctrl slv_i (
        .clk(clk), .rst_n(rst_n), .slave_mode(1'b1), .wr_en(b_wr_s), .addr(b_addr),
        .wr_data(b_data), .rd_data(s_rd), .irq_in(b_sirq), .intr(s_intr), .inta(b_inta),
        .cas_in(m_co), .cas_in_vld(m_cov), .cas_out(s_co), .cas_out_vld(s_cov_unused),
        .vec_out(s_vec), .vec_valid(s_vv)
    );
    assign s_co_unused = {5'd0, s_co};

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference model of the master
    logic [7:0] md_irr, md_isr, md_imr, md_base, md_cas, md_prev, md_vec;
    logic [7:0] nx_irr, nx_isr, irq_now;
    bit   md_aeoi, md_rdisr, md_vv, md_init, slv_intr_s;
    int   md_phase, md_w;

    function automatic int pick(input logic [7:0] r, input logic [7:0] s, input logic [7:0] m);
        int top_s = 8;
        int res = -1;
        for (int i = 7; i >= 0; i--) if (s[i]) top_s = i;
        for (int i = 7; i >= 0; i--) if (i < top_s && r[i] && !m[i]) res = i;
        return res;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            md_irr = 0; md_isr = 0; md_imr = 8'hFF; md_base = 0; md_cas = 0;
            md_prev = 0; md_vec = 0; md_aeoi = 0; md_rdisr = 0; md_vv = 0; md_phase = 0;
        end else begin
            irq_now = {b_irq[7:3], slv_intr_s, b_irq[1:0]};
            md_w = pick(md_irr, md_isr, md_imr);
            nx_irr = md_irr; nx_isr = md_isr; md_vv = 0; md_init = 0;
            for (int i = 0; i < 8; i++) begin
                if (irq_now[i] && !md_prev[i]) nx_irr[i] = 1'b1;
                if (!irq_now[i]) nx_irr[i] = 1'b0;
            end
            if (b_wr_m && !b_addr) begin
                if (b_data[4]) begin
                    md_init = 1; md_rdisr = 0; md_phase = 1;
                end else if (b_data[7:5] == 3'b011) begin
                    nx_isr[b_data[2:0]] = 1'b0;
                end else if (b_data[4:3] == 2'b01 && b_data[1]) begin
                    md_rdisr = b_data[0];
                end
            end else if (b_wr_m && b_addr) begin
                case (md_phase)
                    1: begin md_base = b_data & 8'hF8; md_phase = 2; end
                    2: begin md_cas = b_data; md_phase = 3; end
                    3: begin md_aeoi = b_data[1]; md_phase = 0; end
                    default: md_imr = b_data;
                endcase
            end
            if (b_inta) begin
                if (md_w >= 0) begin
                    nx_irr[md_w] = 1'b0;
                    if (!md_aeoi) nx_isr[md_w] = 1'b1;
                    if (!md_cas[md_w]) begin md_vv = 1; md_vec = md_base | 8'(md_w); end
                end else begin
                    md_vv = 1; md_vec = md_base | 8'd7;
                end
            end
            if (md_init) begin nx_irr = 0; nx_isr = 0; end
            md_prev = irq_now; md_irr = nx_irr; md_isr = nx_isr;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 intr vs model", m_intr, pick(md_irr, md_isr, md_imr) >= 0);
            chk("R3 vec_valid vs model", m_vv, md_vv);
            if (md_vv) chk("R3 vector vs model", m_vec, md_vec);
            chk("R5 read port vs model", m_rd,
                b_addr ? md_imr : (md_rdisr ? md_isr : md_irr));
        end
        slv_intr_s = s_intr;
    end

    task automatic wr(input bit slv, input bit a, input logic [7:0] d);
        @(negedge clk); #2;
        b_addr = a; b_data = d;
        if (slv) b_wr_s = 1; else b_wr_m = 1;
        @(negedge clk); #2;
        b_wr_s = 0; b_wr_m = 0;
    endtask

    task automatic rd(input bit slv, input bit a, output logic [7:0] v);
        @(negedge clk); #2;
        b_addr = a; #1;
        v = slv ? s_rd : m_rd;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #3;
    endtask

    logic [7:0] a_mv, a_sv;
    bit a_mvv, a_svv, a_cov;
    logic [2:0] a_co;

    task automatic ack();
        @(negedge clk); #2;
        b_inta = 1; #1;
        a_co = m_co; a_cov = m_cov;
        @(posedge clk); #2;
        a_mv = m_vec; a_mvv = m_vv; a_sv = s_vec; a_svv = s_vv;
        @(negedge clk); #2;
        b_inta = 0;
    endtask

    task automatic setup(input bit slv, input logic [7:0] base, input logic [7:0] cw, input logic [7:0] mode);
        wr(slv, 0, 8'h11); wr(slv, 1, base); wr(slv, 1, cw); wr(slv, 1, mode);
    endtask

    logic [7:0] v;

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        rd(0, 1, v); chk("R1 mask after reset", v, 8'hFF);
        rd(0, 0, v); chk("R1 request reg after reset", v, 8'h00);
        chk("R1 intr after reset", m_intr, 0);

        setup(0, 8'h20, 8'h04, 8'h01);
        setup(1, 8'h28, 8'h02, 8'h01);
        wr(0, 1, 8'h00); wr(1, 1, 8'h00);
        rd(0, 1, v); chk("R4 mask readback", v, 8'h00);

        @(negedge clk); #2 b_irq = 8'h20;
        tick(2); chk("R6 edge raises intr", m_intr, 1);
        ack(); chk("R3 vector level 5", a_mv, 8'h25); chk("R3 strobe", a_mvv, 1);
        chk("R12 no cascade select for plain input", a_cov, 0);
        wr(0, 0, 8'h0B);
        rd(0, 0, v); chk("R8 in-service after ack", v, 8'h20);
        chk("R7 intr low while level 5 in service", m_intr, 0);

        @(negedge clk); #2 b_irq = 8'h68;
        tick(2); chk("R7 higher level preempts", m_intr, 1);
        ack(); chk("R7 level 3 wins", a_mv, 8'h23);
        rd(0, 0, v); chk("R8 nested in-service", v, 8'h28);
        wr(0, 0, 8'h63);
        rd(0, 0, v); chk("R9 specific EOI clears level 3 only", v, 8'h20);
        chk("R7 lower level blocked by level 5", m_intr, 0);
        wr(0, 0, 8'h65); tick(1);
        chk("R7 level 6 presented after EOI", m_intr, 1);
        ack(); chk("R3 vector level 6", a_mv, 8'h26);
        wr(0, 0, 8'h66);
        rd(0, 0, v); chk("R9 all in-service cleared", v, 8'h00);
        @(negedge clk); #2 b_irq = 8'h00;

        wr(0, 0, 8'h0A);
        @(negedge clk); #2 b_irq = 8'h10;
        tick(1); rd(0, 0, v); chk("R6 edge latched", v, 8'h10);
        @(negedge clk); #2 b_irq = 8'h00;
        tick(1); rd(0, 0, v); chk("R6 request dropped", v, 8'h00);
        ack(); chk("R11 spurious vector", a_mv, 8'h27);
        wr(0, 0, 8'h0B);
        rd(0, 0, v); chk("R11 in-service unchanged", v, 8'h00);
        wr(0, 0, 8'h0A);

        wr(0, 1, 8'h90);
        @(negedge clk); #2 b_irq = 8'h10;
        tick(2); chk("R4 masked request holds intr low", m_intr, 0);
        rd(0, 0, v); chk("R4 masked request still latched", v, 8'h10);
        ack(); chk("R11 spurious with level 7 masked", a_mv, 8'h27);
        wr(0, 1, 8'h00); tick(1);
        chk("R4 unmask presents request", m_intr, 1);
        ack(); chk("R4 unmasked vector", a_mv, 8'h24);
        wr(0, 0, 8'h64);
        @(negedge clk); #2 b_irq = 8'h00;

        @(negedge clk); #2 b_sirq = 8'h08;
        tick(3); chk("R12 slave request reaches master", m_intr, 1);
        ack();
        chk("R12 cascade select level", a_co, 2); chk("R12 cascade select valid", a_cov, 1);
        chk("R12 master gives no vector", a_mvv, 0);
        chk("R13 slave vector", a_sv, 8'h2B); chk("R13 slave strobe", a_svv, 1);
        wr(0, 0, 8'h0B);
        rd(0, 0, v); chk("R12 master cascade in service", v, 8'h04);
        wr(1, 0, 8'h0B);
        rd(1, 0, v); chk("R13 slave in service", v, 8'h08);
        wr(1, 0, 8'h63); wr(0, 0, 8'h62);
        @(negedge clk); #2 b_sirq = 8'h00;
        tick(2);

        @(negedge clk); #2 b_irq = 8'h01; b_sirq = 8'h08;
        tick(3);
        ack();
        chk("R13 master vector level 0", a_mv, 8'h20);
        chk("R13 slave silent when not selected", a_svv, 0);
        rd(1, 0, v); chk("R13 slave in-service untouched", v, 8'h00);
        wr(0, 0, 8'h60);
        ack(); chk("R13 slave answers when selected", a_sv, 8'h2B);
        wr(1, 0, 8'h63); wr(0, 0, 8'h62);
        @(negedge clk); #2 b_irq = 8'h00; b_sirq = 8'h00;

        @(negedge clk); #2 b_irq = 8'h02;
        tick(2); ack(); chk("R8 level 1 acknowledged", a_mv, 8'h21);
        @(negedge clk); #2 b_irq = 8'h0A;
        tick(2);
        wr(0, 0, 8'h11);
        rd(0, 0, v); chk("R2 init clears requests and selects them", v, 8'h00);
        wr(0, 1, 8'h40); wr(0, 1, 8'h04); wr(0, 1, 8'h03);
        rd(0, 1, v); chk("R2 mask kept through init", v, 8'h00);
        wr(0, 0, 8'h0B);
        rd(0, 0, v); chk("R2 init clears in-service", v, 8'h00);
        @(negedge clk); #2 b_irq = 8'h00;
        @(negedge clk); #2 b_irq = 8'h08;
        tick(2); ack(); chk("R2 new base applied", a_mv, 8'h43);
        rd(0, 0, v); chk("R10 auto-EOI sets no in-service bit", v, 8'h00);
        chk("R10 intr low after auto-EOI ack", m_intr, 0);
        tick(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule